// File: doc/BRIEF.md
# Asynchronous Descriptor Re-scan Scheduler

This block decides, within one USB frame, which control or bulk transfer descriptor gets the next bus transaction. It keeps a small table in which every entry has a remaining-byte count, an active flag and a speed flag. After each start-of-frame it walks the table once in ascending order and gives every active entry one transaction. It then keeps circling the table, beginning just past the last entry it served, so that one endpoint can receive several packets in the same frame. This continues for as long as the frame has room.

Each transaction leaves the block as a one-cycle request that carries an entry index and a byte count. The block then waits for a single completion report that gives the bytes actually moved and an error flag. A completion subtracts the moved bytes from the entry. The entry retires when its count reaches zero or when the report flags an error. A frame timer counts down from a reload value at every start-of-frame. A transaction is launched only while the timer is above the sum of a programmable end-of-frame margin (one value for full speed, one for low speed) and an estimate of the packet's duration. When no active entry fits, the block waits for the next start-of-frame. A sticky interrupt for the asynchronous list is raised after a programmable number of completions in the frame, and it stays set until it is cleared.

Top module: `async_rescan_sched`

## Requirements
- R1: After reset no request is issued, `async_irq` is low, every descriptor is inactive and the frame timer is zero, so nothing is scheduled before the first `sof`.
- R2: A pulse on `ld_we` writes `ld_bytes` and `ld_ls` into entry `ld_idx`. A non-zero byte count makes the entry active and a zero count makes it inactive. A load wins over a completion to the same entry in the same cycle.
- R3: A request lasts one cycle and asks for min(remaining, MAX_PKT) bytes. No further request is issued until a completion (`cpl_valid`) has been received.
- R4: A completion subtracts `cpl_bytes` from the served entry, flooring at zero. The entry stays active unless the count reaches zero or `cpl_err` is 1.
- R5: After each `sof` the first pass visits indices 0 to N_DESC-1 in ascending order and serves every active entry that fits exactly once.
- R6: After the first pass, the re-scan visits entries in ascending order with wrap-around, starting at the index after the last entry served. Any entry that is still active and fits gets another transaction.
- R7: A transaction starts only while the frame timer is strictly greater than the margin plus the estimate. The estimate is (bytes + PKT_OVH) for a full-speed entry (`ld_ls`=0) and eight times that value for a low-speed entry (`ld_ls`=1). The margin is `fs_margin` or `ls_margin` according to the same flag.
- R8: The frame timer is a TIME_W-bit down-counter. `sof` reloads it to FRAME_LEN, it drops by one per cycle, and it holds at zero.
- R9: Once a full circle of the table finds nothing that fits, the block stays idle and ignores margin changes until the next `sof`. That `sof` starts a fresh first pass from index 0.
- R10: `async_irq` is set when the completion count since the last `sof` reaches `irq_after` (0 disables). It stays set until `irq_clr` is pulsed. A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse |
| ld_we | input | 1 | Descriptor load strobe |
| ld_idx | input | IDX_W | Descriptor index to load |
| ld_bytes | input | BYTE_W | Total bytes for the descriptor |
| ld_ls | input | 1 | 1 = low-speed endpoint |
| fs_margin | input | TIME_W | End-of-frame margin for full-speed packets |
| ls_margin | input | TIME_W | End-of-frame margin for low-speed packets |
| irq_after | input | CNT_W | Completions per frame before the interrupt |
| irq_clr | input | 1 | Interrupt clear pulse |
| req_valid | output | 1 | Transaction request, one cycle |
| req_idx | output | IDX_W | Descriptor index of the request |
| req_bytes | output | BYTE_W | Bytes asked for |
| cpl_valid | input | 1 | Completion report strobe |
| cpl_bytes | input | BYTE_W | Bytes actually moved |
| cpl_err | input | 1 | Fatal error on the transaction |
| async_irq | output | 1 | Asynchronous-list interrupt |

## Verification
The assertions assume a well-behaved environment. A completion arrives only while a request is outstanding, and exactly one completion arrives per request. Loads never target an entry while it is being served. The bench keeps to this by driving a single responder that answers each request once after a delay of at least one cycle. It reloads the table only while the block is idle between frames, and it pulses `irq_clr` only between transactions.

// File: rtl/async_sched_pkg.sv
package async_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2
  } sched_st_e;
endpackage

// File: rtl/async_frame_timer.sv
module async_frame_timer #(
  parameter int TIME_W    = 12,
  parameter int FRAME_LEN = 1500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  output logic [TIME_W-1:0] time_left
);
  localparam logic [TIME_W-1:0] RELOAD = TIME_W'(FRAME_LEN);

  always_ff @(posedge clk) begin
    if (rst)                  time_left <= '0;
    else if (sof)             time_left <= RELOAD;
    else if (time_left != '0) time_left <= time_left - 1'b1;
  end

  // R8: start-of-frame loads the full budget
  p_reload_r8: assert property (@(posedge clk) disable iff (rst)
    sof |=> time_left == RELOAD);
  // R8: without a start-of-frame the budget never grows
  p_no_growth_r8: assert property (@(posedge clk) disable iff (rst)
    !sof |=> time_left <= $past(time_left));
endmodule

// File: rtl/async_desc_store.sv
module async_desc_store #(
  parameter int N_DESC = 8,
  parameter int BYTE_W = 10,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [BYTE_W-1:0] ld_bytes,
  input  logic              ld_ls,
  input  logic              up_we,
  input  logic [IDX_W-1:0]  up_idx,
  input  logic [BYTE_W-1:0] up_bytes,
  input  logic              up_err,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_rem,
  output logic              rd_act,
  output logic              rd_ls
);
  // byte counts and speed flags live in an unreset array (RAM friendly)
  logic [BYTE_W-1:0] rem_q [N_DESC];
  logic [N_DESC-1:0] ls_q;
  logic [N_DESC-1:0] act_q;
  logic [BYTE_W-1:0] up_new;

  always_comb begin
    up_new = (up_bytes >= rem_q[up_idx]) ? '0 : rem_q[up_idx] - up_bytes;
  end

  always_ff @(posedge clk) begin
    if (up_we) rem_q[up_idx] <= up_new;
    if (ld_we) begin
      rem_q[ld_idx] <= ld_bytes;
      ls_q[ld_idx]  <= ld_ls;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else begin
      if (up_we) act_q[up_idx] <= !(up_err || (up_new == '0));
      if (ld_we) act_q[ld_idx] <= (ld_bytes != '0);
    end
  end

  assign rd_rem = rem_q[rd_idx];
  assign rd_act = act_q[rd_idx];
  assign rd_ls  = ls_q[rd_idx];

  // R4: a fatal error retires the descriptor
  p_err_retires_r4: assert property (@(posedge clk) disable iff (rst)
    (up_we && up_err && !(ld_we && (ld_idx == up_idx))) |=> !act_q[$past(up_idx)]);
  // R2: loading zero bytes leaves the descriptor inactive
  p_zero_load_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_we && (ld_bytes == '0)) |=> !act_q[$past(ld_idx)]);
endmodule

// File: rtl/async_slot_fit.sv
module async_slot_fit #(
  parameter int BYTE_W  = 10,
  parameter int TIME_W  = 12,
  parameter int MAX_PKT = 64,
  parameter int PKT_OVH = 16
) (
  input  logic [BYTE_W-1:0] rem,
  input  logic              ls,
  input  logic [TIME_W-1:0] time_left,
  input  logic [TIME_W-1:0] fs_margin,
  input  logic [TIME_W-1:0] ls_margin,
  output logic [BYTE_W-1:0] chunk,
  output logic              fits
);
  localparam int SUM_W = ((BYTE_W > TIME_W) ? BYTE_W : TIME_W) + 5;
  localparam logic [BYTE_W-1:0] MAXB = BYTE_W'(MAX_PKT);

  logic [SUM_W-1:0] base, est, need;

  always_comb begin
    chunk = (rem > MAXB) ? MAXB : rem;
    base  = SUM_W'(chunk) + SUM_W'(PKT_OVH);
    est   = ls ? (base << 3) : base;
    need  = est + SUM_W'(ls ? ls_margin : fs_margin);
    fits  = SUM_W'(time_left) > need;
  end
endmodule

// File: rtl/async_rescan_sched.sv
module async_rescan_sched import async_sched_pkg::*; #(
  parameter int N_DESC    = 8,
  parameter int BYTE_W    = 10,
  parameter int TIME_W    = 12,
  parameter int FRAME_LEN = 1500,
  parameter int MAX_PKT   = 64,
  parameter int PKT_OVH   = 16,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = (N_DESC > 1) ? $clog2(N_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              ld_we,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [BYTE_W-1:0] ld_bytes,
  input  logic              ld_ls,
  input  logic [TIME_W-1:0] fs_margin,
  input  logic [TIME_W-1:0] ls_margin,
  input  logic [CNT_W-1:0]  irq_after,
  input  logic              irq_clr,
  output logic              req_valid,
  output logic [IDX_W-1:0]  req_idx,
  output logic [BYTE_W-1:0] req_bytes,
  input  logic              cpl_valid,
  input  logic [BYTE_W-1:0] cpl_bytes,
  input  logic              cpl_err,
  output logic              async_irq
);
  localparam int SKIP_W = $clog2(N_DESC + 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(N_DESC - 1);
  localparam logic [SKIP_W-1:0] LAST_SKIP = SKIP_W'(N_DESC - 1);

  sched_st_e         st;
  logic [IDX_W-1:0]  ptr, last_srv;
  logic              first_pass;
  logic [SKIP_W-1:0] skip;
  logic [CNT_W-1:0]  cpl_cnt, cnt_inc;
  logic [TIME_W-1:0] time_left;
  logic [BYTE_W-1:0] rd_rem, chunk;
  logic              rd_act, rd_ls, fits, up_we, cpl_hit;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  async_frame_timer #(.TIME_W(TIME_W), .FRAME_LEN(FRAME_LEN)) u_timer (
    .clk(clk), .rst(rst), .sof(sof), .time_left(time_left)
  );

  assign up_we = (st == ST_WAIT) && cpl_valid;

  async_desc_store #(.N_DESC(N_DESC), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_bytes(ld_bytes), .ld_ls(ld_ls),
    .up_we(up_we), .up_idx(req_idx), .up_bytes(cpl_bytes), .up_err(cpl_err),
    .rd_idx(ptr), .rd_rem(rd_rem), .rd_act(rd_act), .rd_ls(rd_ls)
  );

  async_slot_fit #(.BYTE_W(BYTE_W), .TIME_W(TIME_W), .MAX_PKT(MAX_PKT),
                   .PKT_OVH(PKT_OVH)) u_fit (
    .rem(rd_rem), .ls(rd_ls), .time_left(time_left),
    .fs_margin(fs_margin), .ls_margin(ls_margin),
    .chunk(chunk), .fits(fits)
  );

  assign cnt_inc = (&cpl_cnt) ? cpl_cnt : cpl_cnt + 1'b1;
  assign cpl_hit = up_we && (irq_after != '0) && (cnt_inc == irq_after);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ptr        <= '0;
      last_srv   <= LAST_IDX;
      first_pass <= 1'b1;
      skip       <= '0;
      cpl_cnt    <= '0;
      req_valid  <= 1'b0;
      req_idx    <= '0;
      req_bytes  <= '0;
    end else begin
      req_valid <= 1'b0;
      if (sof) begin
        // fresh frame: restart the first pass, keep an outstanding transaction
        ptr        <= '0;
        last_srv   <= LAST_IDX;
        first_pass <= 1'b1;
        skip       <= '0;
        cpl_cnt    <= '0;
        st         <= (st == ST_WAIT && !cpl_valid) ? ST_WAIT : ST_SCAN;
      end else begin
        case (st)
          ST_SCAN: begin
            if (rd_act && fits) begin
              req_valid <= 1'b1;
              req_idx   <= ptr;
              req_bytes <= chunk;
              last_srv  <= ptr;
              ptr       <= wrap_inc(ptr);
              skip      <= '0;
              if (first_pass && ptr == LAST_IDX) first_pass <= 1'b0;
              st        <= ST_WAIT;
            end else if (first_pass) begin
              if (ptr == LAST_IDX) begin
                first_pass <= 1'b0;
                ptr        <= wrap_inc(last_srv);
                skip       <= '0;
              end else begin
                ptr <= ptr + 1'b1;
              end
            end else begin
              if (skip == LAST_SKIP) st <= ST_IDLE;
              skip <= skip + 1'b1;
              ptr  <= wrap_inc(ptr);
            end
          end
          ST_WAIT: begin
            if (cpl_valid) begin
              st      <= ST_SCAN;
              cpl_cnt <= cnt_inc;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          async_irq <= 1'b0;
    else if (cpl_hit) async_irq <= 1'b1;
    else if (irq_clr) async_irq <= 1'b0;
  end

  // R3: nothing new while a transaction is outstanding
  p_single_outstanding_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !cpl_valid) |=> !req_valid);
  // R3: request size bounded by the packet limit and never empty
  p_req_size_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_bytes != '0) && (req_bytes <= BYTE_W'(MAX_PKT)));
  // R9: idle persists until start-of-frame
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !sof) |=> (st == ST_IDLE) && !req_valid);
  // R10: interrupt only falls on a clear
  p_irq_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(async_irq) |-> $past(irq_clr));
  // R10: interrupt held while not cleared
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (async_irq && !irq_clr) |=> async_irq);
endmodule

// File: tb/async_rescan_sched_tb.sv
module async_rescan_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int BW = 10;
  localparam int TW = 12;
  localparam int FL = 1500;
  localparam int MP = 64;
  localparam int OH = 16;

  logic clk = 1'b0, rst = 1'b1, sof = 1'b0;
  logic ld_we = 1'b0, ld_ls = 1'b0;
  logic [2:0] ld_idx = '0;
  logic [BW-1:0] ld_bytes = '0;
  logic [TW-1:0] fs_margin = '0, ls_margin = '0;
  logic [7:0] irq_after = '0;
  logic irq_clr = 1'b0;
  logic req_valid, async_irq;
  logic [2:0] req_idx;
  logic [BW-1:0] req_bytes;
  logic cpl_valid = 1'b0, cpl_err = 1'b0;
  logic [BW-1:0] cpl_bytes = '0;

  async_rescan_sched #(.N_DESC(N), .BYTE_W(BW), .TIME_W(TW), .FRAME_LEN(FL),
                       .MAX_PKT(MP), .PKT_OVH(OH), .CNT_W(8)) u_dut (
    .clk(clk), .rst(rst), .sof(sof), .ld_we(ld_we), .ld_idx(ld_idx),
    .ld_bytes(ld_bytes), .ld_ls(ld_ls), .fs_margin(fs_margin),
    .ls_margin(ls_margin), .irq_after(irq_after), .irq_clr(irq_clr),
    .req_valid(req_valid), .req_idx(req_idx), .req_bytes(req_bytes),
    .cpl_valid(cpl_valid), .cpl_bytes(cpl_bytes), .cpl_err(cpl_err),
    .async_irq(async_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, ncyc = 0, sof_cyc = 0;
  int m_rem [N];
  bit m_act [N];
  bit m_ls  [N];
  bit m_fp = 1'b1;
  int m_ptr = 0, m_last = N - 1, fcnt = 0;
  bit exp_irq = 1'b0;

  always @(negedge clk) ncyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit fits_m(input int i);
    return !(m_ls[i] && ls_margin != '0);
  endfunction

  function automatic int model_pick();
    if (m_fp)
      for (int i = m_ptr; i < N; i++) if (m_act[i] && fits_m(i)) return i;
    for (int k = 0; k < N; k++) begin
      int i;
      i = (m_last + 1 + k) % N;
      if (m_act[i] && fits_m(i)) return i;
    end
    return -1;
  endfunction

  task automatic model_commit(input int i);
    if (m_fp && (i == N - 1 || i < m_ptr)) m_fp = 1'b0;
    m_last = i;
    m_ptr  = (i + 1) % N;
  endtask

  task automatic load(input int idx, input int bytes, input bit ls);
    ld_we = 1'b1; ld_idx = 3'(idx); ld_bytes = BW'(bytes); ld_ls = ls;
    @(negedge clk);
    ld_we = 1'b0;
    m_rem[idx] = bytes; m_act[idx] = (bytes != 0); m_ls[idx] = ls;
  endtask

  task automatic pulse_sof();
    sof = 1'b1; sof_cyc = ncyc;
    @(negedge clk);
    sof = 1'b0;
    m_fp = 1'b1; m_ptr = 0; m_last = N - 1; fcnt = 0;
  endtask

  task automatic wait_req(input int max_cyc, output bit got);
    got = 1'b0;
    for (int c = 0; c < max_cyc; c++) begin
      if (req_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // answer the request seen now for entry pick; mode 0 = full transfer
  task automatic respond(input int pick, input int mode, input int delay);
    int want, moved, r;
    bit err;
    want = (m_rem[pick] > MP) ? MP : m_rem[pick];
    moved = want; err = 1'b0;
    if (mode != 0) begin
      r = int'($urandom % 10);
      if (r == 0) err = 1'b1;
      else if (r == 1) moved = want / 2;
    end
    model_commit(pick);
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      chk(!req_valid, "R3 no request while outstanding", int'(req_valid), 0);
    end
    cpl_valid = 1'b1; cpl_bytes = BW'(moved); cpl_err = err;
    @(negedge clk);
    cpl_valid = 1'b0; cpl_err = 1'b0;
    m_rem[pick] = (moved >= m_rem[pick]) ? 0 : m_rem[pick] - moved;
    if (err || m_rem[pick] == 0) m_act[pick] = 1'b0;
    fcnt++;
    if (irq_after != 0 && fcnt == int'(irq_after)) exp_irq = 1'b1;
    chk(async_irq == exp_irq, "R10 interrupt after completion", int'(async_irq), int'(exp_irq));
    if (exp_irq && ($urandom % 2 == 1)) begin
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      exp_irq = 1'b0;
      chk(async_irq == 1'b0, "R10 interrupt cleared", int'(async_irq), 0);
    end
  endtask

  task automatic serve_frame(input int mode);
    int pick, want;
    bit got;
    for (int g = 0; g < 300; g++) begin
      pick = model_pick();
      wait_req(60, got);
      if (pick < 0) begin
        chk(!got, "R9 no request once nothing fits", int'(got), 0);
        break;
      end
      chk(got, "R5/R6 expected a request", int'(got), 1);
      if (!got) break;
      want = (m_rem[pick] > MP) ? MP : m_rem[pick];
      chk(int'(req_idx) == pick, "R5/R6 scan order index", int'(req_idx), pick);
      chk(int'(req_bytes) == want, "R3/R4 request byte count", int'(req_bytes), want);
      respond(pick, mode, 1 + int'($urandom % 4));
    end
  endtask

  initial begin
    bit got;
    int cnt, off;
    void'($urandom(32'd7));
    for (int i = 0; i < N; i++) begin m_rem[i] = 0; m_act[i] = 0; m_ls[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_valid == 1'b0, "R1 reset request low", int'(req_valid), 0);
    chk(async_irq == 1'b0, "R1 reset interrupt low", int'(async_irq), 0);
    load(3, 50, 0);
    wait_req(40, got);
    chk(!got, "R1 nothing scheduled before first sof", int'(got), 0);
    load(3, 0, 0);
    pulse_sof();
    serve_frame(0);

    // R5 R6 directed ordering
    load(0, 100, 0); load(2, 30, 0); load(3, 150, 0);
    pulse_sof();
    serve_frame(0);

    // R2 zero load cancels an entry
    load(5, 90, 0); load(5, 0, 0); load(6, 40, 0);
    pulse_sof();
    wait_req(60, got);
    chk(got && req_idx == 3'd6, "R2 zero-byte load leaves entry idle", int'(req_idx), 6);
    if (got) respond(6, 0, 2);
    serve_frame(0);

    // R7 R9 low-speed gate and idle until sof
    ls_margin = TW'(FL - 10);
    load(0, 8, 1); load(1, 8, 0);
    pulse_sof();
    serve_frame(0);
    chk(m_act[0] == 1'b1, "R7 low-speed entry held back", int'(m_act[0]), 1);
    ls_margin = '0;
    wait_req(60, got);
    chk(!got, "R9 idle ignores margin change", int'(got), 0);
    pulse_sof();
    wait_req(60, got);
    chk(got && req_idx == 3'd0, "R9 fresh pass serves low-speed entry", int'(req_idx), 0);
    chk(req_bytes == BW'(8), "R3 short request bytes", int'(req_bytes), 8);
    if (got) respond(0, 0, 1);
    serve_frame(0);

    // R7 R8 end-of-frame margin cuts the re-scan
    fs_margin = TW'(1300);
    load(2, 1000, 0);
    pulse_sof();
    cnt = 0;
    for (int g = 0; g < 20; g++) begin
      wait_req(60, got);
      if (!got) break;
      off = ncyc - sof_cyc;
      chk(off <= 125, "R7 request inside allowed window", off, 125);
      chk(req_idx == 3'd2, "R6 same endpoint repeated", int'(req_idx), 2);
      cnt++;
      respond(2, 0, 20);
    end
    chk(cnt >= 1 && cnt < 15, "R7 time gate limits repeats", cnt, 5);
    fs_margin = '0;
    pulse_sof();
    serve_frame(0);
    chk(m_act[2] == 1'b0, "R4 entry drained after reload", int'(m_act[2]), 0);

    // random frames
    for (int f = 0; f < 12; f++) begin
      for (int i = 0; i < N; i++)
        load(i, ($urandom % 4 == 0) ? 0 : 1 + int'($urandom % 255), 0);
      irq_after = 8'(1 + $urandom % 5);
      pulse_sof();
      serve_frame(1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired actual=150000 expected<150000");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule